// File: doc/BRIEF.md
# Interleaved Multiphase PWM Sequencer

This block drives up to three interleaved, trailing-edge PWM outputs for a multiphase buck regulator. A shared up-counter acts as the sawtooth. A programmable count N sets its length, and one full count is one switching cycle. Phase 1 is always terminated at the start of each cycle. The pulses of the other phases end at fixed fractions of the cycle, and those fractions depend on how many phases are active. After each termination a phase is held off for one third of a cycle so that a current sample can be taken, and a per-phase sample strobe marks that window. Once the forced-off time has passed, a phase turns on at the point where its duty-control word crosses its ramp, and it stays on until its next termination.

The duty words are plain digital inputs, one per phase. Each is the error signal minus that phase's current correction. Two select inputs choose three-, two- or one-phase operation, and three phases is the default. New period and mode settings are only picked up at a cycle boundary, so a running cycle is never reshaped. All drive and strobe outputs are registered.

Top module: `mpwm_sequencer`

## Requirements
- R1: The cycle lasts N clocks, where N is the period input and any value below 3 is treated as 3. The sample window of phase 1 opens, and its pulse ends, once every N clocks.
- R2: With both select inputs low, phase 2 terminates floor(N/3) clocks after phase 1, and phase 3 terminates 2*floor(N/3) clocks after phase 1.
- R3: With the phase-3 disable input high and single select low, phase 2 terminates floor(N/2) clocks after phase 1. The drive and sample outputs of phase 3 stay 0.
- R4: With single select high, whatever the phase-3 disable input is, only phase 1 runs. The drive and sample outputs of phases 2 and 3 stay 0.
- R5: Once a drive output falls, it stays low for at least F = floor(N/3) clocks. A pulse that is cut short because a duty word dropped does not restart before its next termination.
- R6: In each cycle, an active phase is high for min(D, N-F) consecutive clocks, where D is its duty word, and the pulse ends at the phase's termination point. This caps the duty at about two thirds. A duty word of 0 keeps the phase low.
- R7: The sample strobe of an active phase goes high on the clock where its termination point falls (the clock where its drive drops). It stays high for exactly F clocks. It is never high together with that phase's drive, and at most one strobe is high at any time.
- R8: During reset, and from the clock after enable is sampled low, all drive and sample outputs are 0. The first clock after re-enable opens a new cycle with only the phase-1 strobe high.
- R9: The period and mode inputs are taken only at a cycle boundary (and continuously while disabled). The cycle in progress completes with the previous period and termination points.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low forces all outputs to 0 |
| period_i | input | CNT_W | Cycle length N in clocks (minimum 3) |
| ph3_off_i | input | 1 | Phase-3 disable, selects two-phase operation |
| single_i | input | 1 | Single-phase select (overrides ph3_off_i) |
| duty_i | input | 3*CNT_W | Duty-control word per phase, index 0 is phase 1 |
| pwm_o | output | 3 | Drive outputs, bit 0 is phase 1 |
| samp_o | output | 3 | Sample-window strobes, bit 0 is phase 1 |

## Verification
The forced-off property treats a drop of enable as a fresh start. It only measures off-time between falls and rises that happen while the block keeps running, because a restart may open a phase's window early. The duty-bound and window properties assume the period input is at least 3 and the duty words are stable within the cycles being judged. The directed scenarios hold every input steady from well before a measurement window until its end. They change period, mode or enable only at points the scenario controls, then wait out the old cycle before measuring.

// File: rtl/mpwm_pkg.sv
package mpwm_pkg;

    localparam int NPH = 3;

    typedef enum logic [1:0] {
        MODE_THREE = 2'd0,
        MODE_TWO   = 2'd1,
        MODE_ONE   = 2'd2
    } mode_e;

    typedef struct packed {
        logic drive;
        logic sample;
    } ph_stat_t;

    // single select wins over phase-3 disable; three phases otherwise
    function automatic mode_e pick_mode(input logic ph3_off, input logic single);
        if (single)
            return MODE_ONE;
        else if (ph3_off)
            return MODE_TWO;
        else
            return MODE_THREE;
    endfunction

    function automatic logic [NPH-1:0] phase_mask(input mode_e m);
        case (m)
            MODE_THREE: return 3'b111;
            MODE_TWO:   return 3'b011;
            default:    return 3'b001;
        endcase
    endfunction

endpackage

// File: rtl/mpwm_cycle_timer.sv
module mpwm_cycle_timer
    import mpwm_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       en_i,
    input  logic [CNT_W-1:0]           period_i,
    input  logic                       ph3_off_i,
    input  logic                       single_i,
    output logic [CNT_W-1:0]           cnt_o,
    output logic [CNT_W-1:0]           n_o,
    output logic [CNT_W-1:0]           forced_o,
    output logic [NPH-1:0][CNT_W-1:0]  off_o,
    output mode_e                      mode_o,
    output logic [NPH-1:0]             active_o
);

    localparam logic [CNT_W-1:0] MIN_N = CNT_W'(3);
    localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q, n_q, third_q, half_q;
    mode_e            mode_q;

    logic [CNT_W-1:0] n_req, third_req, half_req, step;
    mode_e            mode_req;
    logic             wrap, load;

    // requested settings, division by constants done before the latch
    always_comb begin
        n_req     = (period_i < MIN_N) ? MIN_N : period_i;
        third_req = n_req / CNT_W'(3);
        half_req  = n_req >> 1;
        mode_req  = pick_mode(ph3_off_i, single_i);
    end

    assign wrap = (cnt_q == n_q - ONE);
    assign load = !en_i || wrap;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            n_q     <= MIN_N;
            third_q <= ONE;
            half_q  <= ONE;
            mode_q  <= MODE_THREE;
        end else begin
            if (load) begin
                n_q     <= n_req;
                third_q <= third_req;
                half_q  <= half_req;
                mode_q  <= mode_req;
            end
            if (load)
                cnt_q <= '0;
            else
                cnt_q <= cnt_q + ONE;
        end
    end

    // termination offsets: multiples of the inter-phase step
    assign step = (mode_q == MODE_TWO) ? half_q : third_q;

    always_comb begin
        for (int k = 0; k < NPH; k++)
            off_o[k] = CNT_W'(k) * step;
    end

    assign cnt_o    = cnt_q;
    assign n_o      = n_q;
    assign forced_o = third_q;
    assign mode_o   = mode_q;
    assign active_o = phase_mask(mode_q);

endmodule

// File: rtl/mpwm_phase_unit.sv
module mpwm_phase_unit
    import mpwm_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_i,
    input  logic             active_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] n_i,
    input  logic [CNT_W-1:0] off_i,
    input  logic [CNT_W-1:0] forced_i,
    input  logic [CNT_W-1:0] duty_i,
    output ph_stat_t         stat_o
);

    logic [CNT_W:0] ramp;
    logic           in_forced, in_drive, at_term;
    logic           spent_q, spent_d;
    ph_stat_t       stat_d;

    always_comb begin
        // clocks elapsed since this phase's termination point
        if (cnt_i >= off_i)
            ramp = {1'b0, cnt_i} - {1'b0, off_i};
        else
            ramp = {1'b0, cnt_i} + {1'b0, n_i} - {1'b0, off_i};

        at_term   = (ramp == '0);
        in_forced = ramp < {1'b0, forced_i};
        in_drive  = !in_forced && ((ramp + {1'b0, duty_i}) >= {1'b0, n_i});

        stat_d.drive  = run_i && active_i && in_drive && !spent_q;
        stat_d.sample = run_i && active_i && in_forced;

        // a pulse that ended early stays off until the next termination
        if (!run_i || at_term)
            spent_d = 1'b0;
        else
            spent_d = spent_q || (stat_o.drive && !stat_d.drive);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_o  <= '0;
            spent_q <= 1'b0;
        end else begin
            stat_o  <= stat_d;
            spent_q <= spent_d;
        end
    end

endmodule

// File: rtl/mpwm_sequencer.sv
module mpwm_sequencer
    import mpwm_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      en,
    input  logic [CNT_W-1:0]          period_i,
    input  logic                      ph3_off_i,
    input  logic                      single_i,
    input  logic [NPH-1:0][CNT_W-1:0] duty_i,
    output logic [NPH-1:0]            pwm_o,
    output logic [NPH-1:0]            samp_o
);

    logic [CNT_W-1:0]          cyc_cnt, cfg_n, cfg_forced;
    logic [NPH-1:0][CNT_W-1:0] cfg_off;
    mode_e                     cfg_mode;
    logic [NPH-1:0]            cfg_active;
    ph_stat_t                  stat [NPH];

    mpwm_cycle_timer #(.CNT_W(CNT_W)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .en_i      (en),
        .period_i  (period_i),
        .ph3_off_i (ph3_off_i),
        .single_i  (single_i),
        .cnt_o     (cyc_cnt),
        .n_o       (cfg_n),
        .forced_o  (cfg_forced),
        .off_o     (cfg_off),
        .mode_o    (cfg_mode),
        .active_o  (cfg_active)
    );

    for (genvar g = 0; g < NPH; g++) begin : g_phase
        mpwm_phase_unit #(.CNT_W(CNT_W)) u_unit (
            .clk      (clk),
            .rst      (rst),
            .run_i    (en),
            .active_i (cfg_active[g]),
            .cnt_i    (cyc_cnt),
            .n_i      (cfg_n),
            .off_i    (cfg_off[g]),
            .forced_i (cfg_forced),
            .duty_i   (duty_i[g]),
            .stat_o   (stat[g])
        );
        assign pwm_o[g]  = stat[g].drive;
        assign samp_o[g] = stat[g].sample;
    end

endmodule

// File: rtl/mpwm_sequencer_chk.sv
module mpwm_sequencer_chk
    import mpwm_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic [NPH-1:0]   pwm_o,
    input logic [NPH-1:0]   samp_o,
    input mode_e            mode_q,
    input logic [CNT_W-1:0] forced_q
);

    localparam int             LW  = CNT_W + 1;
    localparam logic [LW-1:0]  SAT = '1;

    p_quiet_when_off_r8: assert property (@(posedge clk) disable iff (rst)
        !en |=> (pwm_o == '0 && samp_o == '0));

    p_single_only_r4: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_ONE) |=> (pwm_o[2:1] == 2'b00 && samp_o[2:1] == 2'b00));

    p_two_no_third_r3: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_TWO) |=> (!pwm_o[2] && !samp_o[2]));

    p_drive_excl_sample_r7: assert property (@(posedge clk) disable iff (rst)
        (pwm_o & samp_o) == '0);

    p_one_window_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(samp_o));

    for (genvar g = 0; g < NPH; g++) begin : g_gap
        logic [LW-1:0]    low_cnt;
        logic [CNT_W-1:0] f_hi, need;

        always_ff @(posedge clk) begin
            if (rst || !en) begin
                low_cnt <= SAT;
                f_hi    <= '0;
            end else if (pwm_o[g]) begin
                low_cnt <= '0;
                f_hi    <= forced_q;
            end else if (low_cnt != SAT) begin
                low_cnt <= low_cnt + 1'b1;
            end
        end

        assign need = (f_hi < forced_q) ? f_hi : forced_q;

        p_forced_gap_r5: assert property (@(posedge clk) disable iff (rst)
            $rose(pwm_o[g]) |-> (low_cnt >= {1'b0, need}));
    end

endmodule

bind mpwm_sequencer mpwm_sequencer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .pwm_o    (pwm_o),
    .samp_o   (samp_o),
    .mode_q   (cfg_mode),
    .forced_q (cfg_forced)
);

// File: tb/mpwm_sequencer_tb_top.sv
module mpwm_sequencer_tb_top;
    import mpwm_pkg::*;

    localparam int W = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en = 1'b0;
    logic ph3_off = 1'b0;
    logic single = 1'b0;
    logic [W-1:0] period = W'(30);
    logic [2:0][W-1:0] duty = '0;
    logic [2:0] pwm, samp;

    always #5 clk = ~clk;

    mpwm_sequencer #(.CNT_W(W)) dut_i (
        .clk(clk), .rst(rst), .en(en), .period_i(period),
        .ph3_off_i(ph3_off), .single_i(single), .duty_i(duty),
        .pwm_o(pwm), .samp_o(samp)
    );

    int nchk = 0, nerr = 0;
    bit done = 0;

    // output recorder, sampled on the falling clock edge
    int tcnt = 0;
    bit rec = 0;
    int srise [3][16];
    int nsr [3], hi_cnt [3], scnt [3], last_run [3], cur_run [3];
    int last_width [3], rise_t [3], fall_t [3], min_low [3];
    int overlap, cobad;
    logic [2:0] pp = '0, sp = '0;

    always @(negedge clk) begin
        tcnt++;
        if (rec) begin
            for (int k = 0; k < 3; k++) begin
                if (pwm[k] && !pp[k]) begin
                    if (fall_t[k] >= 0 && (tcnt - fall_t[k]) < min_low[k])
                        min_low[k] = tcnt - fall_t[k];
                    rise_t[k] = tcnt;
                end
                if (!pwm[k] && pp[k]) begin
                    if (rise_t[k] >= 0) last_width[k] = tcnt - rise_t[k];
                    fall_t[k] = tcnt;
                    if (!(samp[k] && !sp[k])) cobad++;
                end
                if (samp[k] && !sp[k]) begin
                    if (nsr[k] < 16) srise[k][nsr[k]] = tcnt;
                    nsr[k]++;
                    cur_run[k] = 1;
                end else if (samp[k] && cur_run[k] > 0) begin
                    cur_run[k]++;
                end else if (!samp[k] && sp[k]) begin
                    if (cur_run[k] > 0) last_run[k] = cur_run[k];
                    cur_run[k] = 0;
                end
                if (pwm[k]) hi_cnt[k]++;
                if (samp[k]) scnt[k]++;
                if (pwm[k] && samp[k]) overlap++;
            end
        end
        pp = pwm;
        sp = samp;
    end

    task automatic clear_rec();
        rec = 0;
        for (int k = 0; k < 3; k++) begin
            nsr[k] = 0; hi_cnt[k] = 0; scnt[k] = 0; last_run[k] = -1; cur_run[k] = 0;
            last_width[k] = -1; rise_t[k] = -1; fall_t[k] = -1; min_low[k] = 1000000;
        end
        overlap = 0;
        cobad = 0;
        rec = 1;
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int first_after(input int k, input int t);
        for (int i = 0; i < nsr[k] && i < 16; i++)
            if (srise[k][i] > t) return srise[k][i];
        return -1;
    endfunction

    // steady-state measurement of one configuration
    task automatic run_case(input string mreq, input int n, input int f,
                            input int off2, input int off3,
                            input int w0, input int w1, input int w2,
                            input logic [2:0] act);
        int w [3];
        int ref1;
        w[0] = w0; w[1] = w1; w[2] = w2;
        repeat (2 * n + 60) @(posedge clk);
        #1 clear_rec();
        repeat (3 * n + 6) @(posedge clk);
        #1 rec = 0;
        chk(nsr[0] >= 3, "R1", "phase1 windows seen", nsr[0], 3);
        ref1 = srise[0][1];
        chk(srise[0][2] - ref1 == n, "R1", "cycle length", srise[0][2] - ref1, n);
        if (act[1]) chk(first_after(1, ref1) - ref1 == off2, mreq, "phase2 offset",
                        first_after(1, ref1) - ref1, off2);
        if (act[2]) chk(first_after(2, ref1) - ref1 == off3, mreq, "phase3 offset",
                        first_after(2, ref1) - ref1, off3);
        for (int k = 0; k < 3; k++) begin
            if (act[k]) begin
                if (w[k] == 0)
                    chk(hi_cnt[k] == 0, "R6", "zero duty high clocks", hi_cnt[k], 0);
                else begin
                    chk(last_width[k] == w[k], "R6", "pulse width", last_width[k], w[k]);
                    chk(min_low[k] >= f, "R5", "min off time", min_low[k], f);
                end
                chk(last_run[k] == f, "R7", "sample window length", last_run[k], f);
            end else begin
                chk(hi_cnt[k] == 0 && scnt[k] == 0, mreq, "idle phase activity",
                    hi_cnt[k] + scnt[k], 0);
            end
        end
        chk(overlap == 0, "R7", "drive with sample", overlap, 0);
        chk(cobad == 0, "R7", "fall without window start", cobad, 0);
    endtask

    task automatic t_reset();
        chk(pwm == 3'b000, "R8", "reset drive", int'(pwm), 0);
        chk(samp == 3'b000, "R8", "reset sample", int'(samp), 0);
    endtask

    task automatic t_three_even();
        period = W'(30); duty[0] = W'(12); duty[1] = W'(15); duty[2] = W'(25);
        ph3_off = 0; single = 0; en = 1;
        run_case("R2", 30, 10, 10, 20, 12, 15, 20, 3'b111);
    endtask

    task automatic t_three_odd();
        period = W'(31); duty[0] = W'(30); duty[1] = W'(5); duty[2] = W'(21);
        run_case("R2", 31, 10, 10, 20, 21, 5, 21, 3'b111);
    endtask

    task automatic t_two();
        ph3_off = 1; period = W'(40);
        duty[0] = W'(20); duty[1] = W'(30); duty[2] = W'(30);
        run_case("R3", 40, 13, 20, 0, 20, 27, 0, 3'b011);
    endtask

    task automatic t_single();
        single = 1; ph3_off = 1; period = W'(24);
        duty[0] = W'(20); duty[1] = W'(20); duty[2] = W'(20);
        run_case("R4", 24, 8, 0, 0, 16, 0, 0, 3'b001);
    endtask

    task automatic t_zero_duty();
        single = 0; ph3_off = 0; period = W'(30); duty = '0;
        run_case("R2", 30, 10, 10, 20, 0, 0, 0, 3'b111);
    endtask

    task automatic t_clamp();
        period = W'(1); duty[0] = W'(3); duty[1] = W'(3); duty[2] = W'(3);
        run_case("R1", 3, 1, 1, 2, 2, 2, 2, 3'b111);
    endtask

    task automatic t_boundary();
        int s0, s1;
        period = W'(30); duty[0] = W'(12); duty[1] = W'(15); duty[2] = W'(25);
        ph3_off = 0; single = 0;
        repeat (120) @(posedge clk);
        #1 clear_rec();
        while (nsr[0] < 1) @(posedge clk);
        #1;
        repeat (5) @(posedge clk);
        #1 period = W'(45); ph3_off = 1;
        repeat (140) @(posedge clk);
        #1 rec = 0;
        s0 = srise[0][0];
        s1 = srise[0][1];
        chk(s1 - s0 == 30, "R9", "old cycle completes", s1 - s0, 30);
        chk(srise[0][2] - s1 == 45, "R9", "new cycle length", srise[0][2] - s1, 45);
        chk(first_after(1, s0) - s0 == 10, "R9", "old phase2 offset kept",
            first_after(1, s0) - s0, 10);
        chk(first_after(1, s1) - s1 == 22, "R9", "new phase2 offset",
            first_after(1, s1) - s1, 22);
        chk(first_after(2, s1) == -1, "R9", "phase3 off after boundary",
            first_after(2, s1), -1);
    endtask

    task automatic t_enable();
        en = 0;
        @(posedge clk);
        #1;
        chk(pwm == 3'b000 && samp == 3'b000, "R8", "outputs after disable",
            int'({pwm, samp}), 0);
        repeat (5) @(posedge clk);
        #1;
        chk(pwm == 3'b000 && samp == 3'b000, "R8", "outputs held disabled",
            int'({pwm, samp}), 0);
        en = 1;
        @(posedge clk);
        #1;
        chk(samp == 3'b001, "R8", "restart sample", int'(samp), 1);
        chk(pwm == 3'b000, "R8", "restart drive", int'(pwm), 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        rst = 0;
        t_three_even();
        t_three_odd();
        t_two();
        t_single();
        t_zero_duty();
        t_clamp();
        t_boundary();
        t_enable();
        finish_run();
    end

    initial begin
        #(10 * 200000);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            finish_run();
        end
    end

endmodule